// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block chooses which local interrupt a hart should take next. It holds the pending-interrupt register. Requesters change that register through a masked update port, and the port returns the value that stood before the write. The block combines the pending bits with an enable vector, a delegation mask, the current privilege level and the global machine and supervisor enable bits. From that it produces one registered result: a valid flag and the index of the winning interrupt.

Each interrupt is gated by the global enable of the level that would handle it. Bits that are not delegated are gated by the machine-level rule. Delegated bits are gated by the supervisor-level rule. A two-state request controller drives a level line to the core. The line goes up when the pending register leaves the all-zero state and drops when the register returns to it. The controller has two states. REQ_IDLE moves to REQ_ACTIVE on the transition "fill", taken when the next pending value is non-zero. REQ_ACTIVE moves back to REQ_IDLE on the transition "drain", taken when the next pending value is zero. In every other case each state holds.

Top module: `irqsel_top`

## Requirements
- R1: During reset and in the first cycle after it, the pending register is zero, `core_req` is low, `sel_valid` is low and `sel_index` is zero.
- R2: When `upd_en` is high at a clock edge, the pending register becomes (old AND NOT `upd_mask`) OR (`upd_value` AND `upd_mask`). `upd_old` always shows the pending register's current value, before any write in progress takes effect. A mask of zero leaves the register unchanged.
- R3: An interrupt bit can be chosen only if it is set both in the pending register and in `irq_en`.
- R4: A bit whose `irq_deleg` bit is 0 is eligible in two cases: when `priv` is below 3 (machine), or when `priv` equals 3 and `m_ie` is 1. Privilege encoding: 0 user, 1 supervisor, 3 machine.
- R5: A bit whose `irq_deleg` bit is 1 is eligible in two cases: when `priv` is 0, or when `priv` equals 1 and `s_ie` is 1.
- R6: When several bits are eligible, the lowest-numbered one wins. `sel_index` gives its bit position, with bit 0 as the least significant bit of the vectors.
- R7: When no bit is eligible, `sel_valid` is 0 and `sel_index` is 0.
- R8: `core_req` rises in the cycle after an update that takes the pending register from zero to non-zero. It falls in the cycle after an update that takes it from non-zero to zero. It is otherwise unchanged.
- R9: `sel_valid`/`sel_index` are registered. They reflect the pending register, enables, delegation, privilege and global enables as they stood during the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Apply a masked pending update at this edge |
| upd_mask | input | 12 | Bits of the pending register to replace |
| upd_value | input | 12 | New values for the masked bits |
| upd_old | output | 12 | Pending register value before the update |
| irq_en | input | 12 | Per-interrupt enable |
| irq_deleg | input | 12 | 1 = interrupt handled at supervisor level |
| priv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| m_ie | input | 1 | Machine global interrupt enable |
| s_ie | input | 1 | Supervisor global interrupt enable |
| core_req | output | 1 | Level request to the core: pending register non-zero |
| sel_valid | output | 1 | An interrupt qualifies |
| sel_index | output | 4 | Index of the chosen interrupt |

## Verification
Two functions can land in the same cycle. One is a pending update that changes the register. The other is a selection computed from the register's pre-update value. The bench issues updates while the enables and privilege also change, and the behavioural model checks that the selection registered at that edge uses the old pending bits. It also checks that the request line and `upd_old` follow the new bits one cycle later. A second overlap comes from an update that clears some bits while setting others. That update must not toggle `core_req`, and the bench judges this on the cycle after it.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_e;
endpackage

// File: rtl/irqsel_pend_reg.sv
module irqsel_pend_reg #(
    parameter int NUM_IRQ = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [NUM_IRQ-1:0] upd_mask,
    input  logic [NUM_IRQ-1:0] upd_value,
    output logic [NUM_IRQ-1:0] pend_q,
    output logic [NUM_IRQ-1:0] pend_d
);
    always_comb begin
        pend_d = pend_q;
        if (upd_en) begin
            pend_d = (pend_q & ~upd_mask) | (upd_value & upd_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/irqsel_req_fsm.sv
module irqsel_req_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic next_nonzero,
    output logic core_req
);
    import irqsel_pkg::*;

    req_state_e state_q;
    req_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (next_nonzero)  state_d = REQ_ACTIVE;
            REQ_ACTIVE: if (!next_nonzero) state_d = REQ_IDLE;
            default:    state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        core_req = (state_q == REQ_ACTIVE);
    end
endmodule

// File: rtl/irqsel_gate.sv
module irqsel_gate #(
    parameter int NUM_IRQ = 12
) (
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] enable,
    input  logic [NUM_IRQ-1:0] deleg,
    input  logic [1:0]         priv,
    input  logic               m_ie,
    input  logic               s_ie,
    output logic [NUM_IRQ-1:0] eligible
);
    import irqsel_pkg::*;

    priv_e lvl;
    logic  mach_ok;
    logic  super_ok;
    logic [NUM_IRQ-1:0] cand;

    always_comb begin
        lvl      = priv_e'(priv);
        mach_ok  = (lvl < PRIV_MACH)  || ((lvl == PRIV_MACH)  && m_ie);
        super_ok = (lvl < PRIV_SUPER) || ((lvl == PRIV_SUPER) && s_ie);
        cand     = pend & enable;
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
        assign eligible[g] = cand[g] && (deleg[g] ? super_ok : mach_ok);
    end
endmodule

// File: rtl/irqsel_prio.sv
module irqsel_prio #(
    parameter int NUM_IRQ = 12,
    localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   index
);
    always_comb begin
        found = 1'b0;
        index = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                index = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top #(
    parameter int NUM_IRQ = 12,
    localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [NUM_IRQ-1:0] upd_mask,
    input  logic [NUM_IRQ-1:0] upd_value,
    output logic [NUM_IRQ-1:0] upd_old,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic [NUM_IRQ-1:0] irq_deleg,
    input  logic [1:0]         priv,
    input  logic               m_ie,
    input  logic               s_ie,
    output logic               core_req,
    output logic               sel_valid,
    output logic [IDX_W-1:0]   sel_index
);
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] pend_d;
    logic [NUM_IRQ-1:0] eligible;
    logic               found;
    logic [IDX_W-1:0]   index;

    irqsel_pend_reg #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .upd_mask  (upd_mask),
        .upd_value (upd_value),
        .pend_q    (pend_q),
        .pend_d    (pend_d)
    );

    irqsel_req_fsm u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .next_nonzero (|pend_d),
        .core_req     (core_req)
    );

    irqsel_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .pend     (pend_q),
        .enable   (irq_en),
        .deleg    (irq_deleg),
        .priv     (priv),
        .m_ie     (m_ie),
        .s_ie     (s_ie),
        .eligible (eligible)
    );

    irqsel_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .req   (eligible),
        .found (found),
        .index (index)
    );

    assign upd_old = pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            sel_index <= '0;
        end else begin
            sel_valid <= found;
            sel_index <= index;
        end
    end
endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk #(
    parameter int NUM_IRQ = 12,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_en,
    input logic [NUM_IRQ-1:0] upd_mask,
    input logic [NUM_IRQ-1:0] upd_value,
    input logic [NUM_IRQ-1:0] upd_old,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic [NUM_IRQ-1:0] irq_deleg,
    input logic [1:0]         priv,
    input logic               m_ie,
    input logic               s_ie,
    input logic               core_req,
    input logic               sel_valid,
    input logic [IDX_W-1:0]   sel_index
);
    a_r2_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> upd_old == (($past(upd_old) & ~$past(upd_mask)) |
                               ($past(upd_value) & $past(upd_mask))));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(upd_old));

    a_r8_req_level: assert property (@(posedge clk) disable iff (!rst_n)
        core_req == (upd_old != '0));

    a_r7_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> sel_index == '0);

    a_r3_chosen_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ((($past(upd_old) & $past(irq_en)) >> sel_index) & NUM_IRQ'(1)) != '0);

    a_r5_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (((($past(irq_deleg) >> sel_index) & NUM_IRQ'(1)) != '0) ?
            (($past(priv) == 2'd0) || (($past(priv) == 2'd1) && $past(s_ie))) :
            (($past(priv) != 2'd3) || $past(m_ie))));
endmodule

bind irqsel_top irqsel_chk #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/irqsel_top_bench.sv
`timescale 1ns/1ps
module irqsel_top_bench;
    localparam int N = 12;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         upd_en;
    logic [N-1:0] upd_mask, upd_value, upd_old, irq_en, irq_deleg;
    logic [1:0]   priv;
    logic         m_ie, s_ie;
    logic         core_req, sel_valid;
    logic [W-1:0] sel_index;

    always #2.5 clk = ~clk;

    irqsel_top u_irqsel_top (.*);

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    string last_tag = "R1";

    logic [N-1:0] m_pend;
    logic         m_req, m_valid;
    int           m_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_req = 1'b0; m_valid = 1'b0; m_idx = 0;
        end else begin
            m_valid = 1'b0; m_idx = 0;
            for (int i = 0; i < N; i++) begin
                bit ok;
                if (irq_deleg[i]) ok = (priv == 0) || (priv == 1 && s_ie);
                else              ok = (priv != 3) || m_ie;
                if (!m_valid && m_pend[i] && irq_en[i] && ok) begin
                    m_valid = 1'b1; m_idx = i;
                end
            end
            if (upd_en) m_pend = (m_pend & ~upd_mask) | (upd_value & upd_mask);
            m_req = (m_pend != 0);
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check("R8", "core_req", int'(core_req), int'(m_req));
        check(last_tag, "sel_valid", int'(sel_valid), int'(m_valid));
        check(last_tag, "sel_index", int'(sel_index), m_idx);
    endtask

    task automatic step(string tag, bit ue, logic [N-1:0] msk, logic [N-1:0] val,
                        logic [N-1:0] en, logic [N-1:0] dg, logic [1:0] pv,
                        bit mi, bit si);
        @(negedge clk);
        compare_outputs();
        upd_en = ue; upd_mask = msk; upd_value = val;
        irq_en = en; irq_deleg = dg; priv = pv; m_ie = mi; s_ie = si;
        last_tag = tag;
        #0.5;
        check("R2", "upd_old", int'(upd_old), int'(m_pend));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; upd_en = 0; upd_mask = 0; upd_value = 0;
        irq_en = 0; irq_deleg = 0; priv = 0; m_ie = 0; s_ie = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "core_req", int'(core_req), 0);
        check("R1", "sel_valid", int'(sel_valid), 0);
        check("R1", "sel_index", int'(sel_index), 0);
        check("R1", "upd_old", int'(upd_old), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "sel_valid", int'(sel_valid), 0);
        check("R1", "core_req", int'(core_req), 0);
        // R8 fill: bits 5 and 7 pending, user level, all enabled
        step("R9", 1, 12'hFFF, 12'h0A0, 12'hFFF, 12'h000, 2'd0, 0, 0);
        step("R6", 0, 0, 0, 12'hFFF, 12'h000, 2'd0, 0, 0);
        step("R6", 0, 0, 0, 12'hFFF, 12'h000, 2'd0, 0, 0);
        // R3: enable masks off bit 5, then everything
        step("R3", 0, 0, 0, 12'h080, 12'h000, 2'd0, 0, 0);
        step("R3", 0, 0, 0, 12'h000, 12'h000, 2'd0, 0, 0);
        step("R7", 0, 0, 0, 12'h000, 12'h000, 2'd0, 0, 0);
        // R4: machine level, global enable off then on
        step("R4", 0, 0, 0, 12'hFFF, 12'h000, 2'd3, 0, 1);
        step("R4", 0, 0, 0, 12'hFFF, 12'h000, 2'd3, 1, 0);
        // R5: bit 5 delegated; machine level cannot take it
        step("R5", 0, 0, 0, 12'hFFF, 12'h020, 2'd3, 1, 1);
        step("R5", 0, 0, 0, 12'hFFF, 12'h020, 2'd1, 0, 0);
        step("R5", 0, 0, 0, 12'hFFF, 12'h020, 2'd1, 0, 1);
        step("R5", 0, 0, 0, 12'hFFF, 12'hFFF, 2'd0, 0, 0);
        step("R5", 0, 0, 0, 12'hFFF, 12'hFFF, 2'd3, 1, 1);
        // R2: masked update concurrent with privilege change
        step("R2", 1, 12'h0F0, 12'h010, 12'hFFF, 12'h000, 2'd1, 0, 0);
        step("R2", 1, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 2'd1, 0, 0);
        step("R6", 0, 0, 0, 12'hFFF, 12'h000, 2'd1, 0, 0);
        // R8: swap bits without passing through zero, then drain
        step("R8", 1, 12'hFFF, 12'h800, 12'hFFF, 12'h000, 2'd0, 0, 0);
        step("R6", 0, 0, 0, 12'hFFF, 12'h000, 2'd0, 0, 0);
        step("R6", 1, 12'h001, 12'h001, 12'hFFF, 12'h000, 2'd0, 0, 0);
        step("R6", 0, 0, 0, 12'hFFF, 12'h000, 2'd0, 0, 0);
        step("R8", 1, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 2'd0, 0, 0);
        step("R7", 0, 0, 0, 12'hFFF, 12'h000, 2'd0, 0, 0);
        step("R7", 0, 0, 0, 12'hFFF, 12'h000, 2'd0, 0, 0);
        // sweep of single-bit patterns across levels
        for (int b = 0; b < N; b++) begin
            step("R6", 1, 12'hFFF, N'(1) << b, 12'hFFF, N'(b % 3), 2'(b % 2), b[0], b[1]);
            step("R4", 0, 0, 0, 12'hFFF, N'(b % 3), 2'd3, b[1], 0);
        end
        step("R7", 1, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 2'd0, 0, 0);
        step("R7", 0, 0, 0, 12'hFFF, 12'h000, 2'd0, 0, 0);
        @(negedge clk);
        compare_outputs();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule